// File: doc/BRIEF.md
# Sequential shift-add unsigned multiplier

This block multiplies two unsigned operands of `WIDTH` bits over several clocks and returns a product of `2*WIDTH` bits. A start pulse loads the multiplicand into a holding register, the multiplier into the low product register and zero into the high (accumulator) register. On each following clock the block looks at the low bit of the low register. When that bit is one, it adds the multiplicand into the accumulator. It then shifts the carry, accumulator and low register right by one place as a single wide value.

After `WIDTH` such steps the high half of the product sits in the accumulator and the low half in the low register. Busy drops and done pulses for one clock. The result stays on the output until the next accepted start, so a consumer may read it at leisure.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and product_o is 0.
- R2: A start_i seen at a clock edge while busy_o is 0 loads the operands. After that edge busy_o is 1 and product_o equals {WIDTH zeros, mplier_i}.
- R3: done_o rises exactly WIDTH clocks after the edge that accepted start_i. It is high for one clock only, and busy_o is 0 while it is high.
- R4: busy_o stays 1 for exactly WIDTH consecutive clocks per operation.
- R5: When done_o is 1, product_o equals the unsigned product of the accepted multiplicand and multiplier.
- R6: A start_i that arrives while busy_o is 1 is ignored. The running operation keeps its operands and its timing.
- R7: While idle, product_o holds its value until the next accepted start_i, whatever the operand inputs do.
- R8: Each step adds the multiplicand into the accumulator when the low product bit is 1, keeps the carry of that addition, then shifts {carry, acc, low} right by one. For multiplicand 0110 and multiplier 0101, product_o reads 0x05 after the load and 0x32 after the first step. For 1011 × 1101 it ends at 143.
- R9: Boundary operands behave correctly: a zero operand gives 0, and all ones times all ones gives (2^WIDTH−1)^2. The carry of the addition is kept in the top bit of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock pulse when the product is ready |
| product_o | output | 2*WIDTH | Accumulator (high half) and low register (low half) |

## Verification
A corrupted step shows up at product_o on the very next clock, because the output is the live accumulator and low register. The directed intermediate check after the first step catches an add or shift fault within one cycle. A counter off by one shows up as done_o arriving a clock early or late, and a dropped carry shows up only in the final product. For that reason the 4-bit operand space is swept completely, and random 8-bit pairs exercise wide carries. A start accepted while busy would change either the done timing or the final value of that operation.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  function automatic int unsigned cnt_bits(int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/mul_step.sv
// One conditional-add-and-shift step, combinational
module mul_step #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] low_i,
  input  logic [WIDTH-1:0] mcand_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] low_o
);
  logic [WIDTH:0]         sum;
  logic [2*WIDTH:0]       wide;

  always_comb begin
    sum  = {1'b0, acc_i} + (low_i[0] ? {1'b0, mcand_i} : '0);
    wide = {sum, low_i} >> 1;  // carry falls into acc msb
    acc_o = wide[2*WIDTH-1:WIDTH];
    low_o = wide[WIDTH-1:0];
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = cnt_bits(WIDTH);

  logic [CW-1:0] count_q;
  logic          busy_q, done_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        count_q <= CW'(WIDTH);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        count_q <= count_q - CW'(1);
        if (count_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r4_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && count_q != CW'(1)) |=> busy_q);
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && count_q != CW'(1)) |=> (count_q == $past(count_q) - CW'(1)));
endmodule

// File: rtl/mul_dp.sv
module mul_dp #(
  parameter int unsigned WIDTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] acc_q, low_q, m_q;
  logic [WIDTH-1:0] acc_nx, low_nx;

  mul_step #(.WIDTH(WIDTH)) u_step (
    .acc_i  (acc_q),
    .low_i  (low_q),
    .mcand_i(m_q),
    .acc_o  (acc_nx),
    .low_o  (low_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      low_q <= '0;
      m_q   <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      low_q <= mplier_i;
      m_q   <= mcand_i;
    end else if (step_i) begin
      acc_q <= acc_nx;
      low_q <= low_nx;
    end
  end

  assign product_o = {acc_q, low_q};

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q == '0 && low_q == $past(mplier_i) && m_q == $past(mcand_i)));
  a_r6_mcand_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(m_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned WIDTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic load, step;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o)
  );

  // shadow operands, used only by the assertions below
  logic [WIDTH-1:0] chk_a, chk_b;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_a <= '0;
      chk_b <= '0;
    end else if (start_i && !busy_o) begin
      chk_a <= mcand_i;
      chk_b <= mplier_i;
    end
  end

  a_r5_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (product_o == ({{WIDTH{1'b0}}, chk_a} * {{WIDTH{1'b0}}, chk_b})));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (!busy_o && !done_o && product_o == PW'(0)));
endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_run = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  logic       s4_start = 1'b0;
  logic [3:0] s4_a = '0, s4_b = '0;
  logic       s4_busy, s4_done;
  logic [7:0] s4_p;

  logic        s8_start = 1'b0;
  logic [7:0]  s8_a = '0, s8_b = '0;
  logic        s8_busy, s8_done;
  logic [15:0] s8_p;

  shift_add_mul #(.WIDTH(4)) u_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s4_start), .mcand_i(s4_a),
    .mplier_i(s4_b), .busy_o(s4_busy), .done_o(s4_done), .product_o(s4_p));

  shift_add_mul #(.WIDTH(8)) u_shift_add_mul8 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s8_start), .mcand_i(s8_a),
    .mplier_i(s8_b), .busy_o(s8_busy), .done_o(s8_done), .product_o(s8_p));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one 4-bit op; returns product and clocks from accept to done
  task automatic run4(input logic [3:0] a, input logic [3:0] b,
                      output logic [7:0] p, output int cyc);
    @(negedge clk);
    s4_a = a; s4_b = b; s4_start = 1'b1;
    @(negedge clk);
    s4_start = 1'b0;
    cyc = 0;
    while (!s4_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    p = s4_p;
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b,
                      output logic [15:0] p, output int cyc);
    @(negedge clk);
    s8_a = a; s8_b = b; s8_start = 1'b1;
    @(negedge clk);
    s8_start = 1'b0;
    cyc = 0;
    while (!s8_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    p = s8_p;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(s4_busy), 0);
    chk("R1 done", 32'(s4_done), 0);
    chk("R1 product", 32'(s4_p), 0);
    chk("R1 product8", 32'(s8_p), 0);
  endtask

  task automatic t_trace();
    @(negedge clk);
    s4_a = 4'b0110; s4_b = 4'b0101; s4_start = 1'b1;
    @(negedge clk);
    s4_start = 1'b0;
    chk("R2 busy after load", 32'(s4_busy), 1);
    chk("R2/R8 loaded value", 32'(s4_p), 32'h05);
    @(negedge clk);
    chk("R8 after first step", 32'(s4_p), 32'h32);
    for (int i = 0; i < 3; i++) begin
      chk("R4 busy during op", 32'(s4_busy), 1);
      @(negedge clk);
    end
    chk("R3 done on time", 32'(s4_done), 1);
    chk("R3 busy low at done", 32'(s4_busy), 0);
    chk("R8 result 30", 32'(s4_p), 30);
    @(negedge clk);
    chk("R3 done one clock", 32'(s4_done), 0);
  endtask

  task automatic t_example();
    logic [7:0] p; int cyc;
    run4(4'b1011, 4'b1101, p, cyc);
    chk("R8 result 143", 32'(p), 143);
    chk("R3 latency", 32'(cyc), 4);
  endtask

  task automatic t_bounds();
    logic [7:0] p; int cyc;
    run4(4'd0, 4'd9, p, cyc);  chk("R9 zero mcand", 32'(p), 0);
    run4(4'd9, 4'd0, p, cyc);  chk("R9 zero mplier", 32'(p), 0);
    run4(4'hF, 4'hF, p, cyc);  chk("R9 max", 32'(p), 225);
  endtask

  task automatic t_busy_start();
    logic [7:0] p; int cyc;
    @(negedge clk);
    s4_a = 4'd3; s4_b = 4'd5; s4_start = 1'b1;
    @(negedge clk);
    s4_a = 4'd15; s4_b = 4'd14;  // start held high while busy
    @(negedge clk);
    s4_start = 1'b0;
    cyc = 1;
    while (!s4_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk("R6 timing unchanged", 32'(cyc), 4);
    chk("R6 operands kept", 32'(s4_p), 15);
    p = s4_p;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s4_a = 4'(i + 7); s4_b = 4'(i + 2);
    end
    @(negedge clk);
    chk("R7 product held", 32'(s4_p), 32'(p));
    chk("R7 stays idle", 32'(s4_busy), 0);
  endtask

  task automatic t_exhaustive4();
    logic [7:0] p; int cyc; int bad = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run4(4'(a), 4'(b), p, cyc);
        if (p !== 8'(a * b) || cyc != 4) begin
          bad++;
          $display("FAIL R5 a=%0d b=%0d actual=%0d expected=%0d cyc=%0d",
                   a, b, p, a * b, cyc);
        end
      end
    n_run++;
    if (bad != 0) n_fail++;
  endtask

  task automatic t_random8();
    logic [15:0] p; int cyc;
    run8(8'hFF, 8'hFF, p, cyc);
    chk("R9 max 8-bit", 32'(p), 65025);
    chk("R3 latency 8-bit", 32'(cyc), 8);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      run8(a, b, p, cyc);
      chk("R5 random 8-bit", 32'(p), 32'(a) * 32'(b));
    end
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trace();
    t_example();
    t_bounds();
    t_busy_start();
    t_exhaustive4();
    t_random8();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule